// File: doc/BRIEF.md
# Dual-Mode Tick Counter Timer

This block is a bus-attached timer with 32-bit registers. A tick counter advances by one on every clock cycle where the tick-enable input is high. At a 2 MHz tick rate, one tick is 500 ns. Software sees the count shifted left by nine, so each tick adds 0x200 to the visible value and the nine low bits always read zero.

The block has two modes, chosen through a register.

- **System mode:** the counter runs up to a programmable limit and then restarts from zero. At that point it latches a reached flag in bit 31 of the count register and raises the interrupt line. Reading the limit register acknowledges the event.
- **User mode:** the same counter is a wide free-running count split over two words. Software can stop and restart it, and the interrupt line stays low.

Reads are registered. The data appears on the read bus in the cycle after the read strobe and holds until the next read.

Top module: `dmt_timer`

## Requirements
- R1: After reset the limit reads 0x7FFFFE00, the count and reached flag are zero, the mode is system (mode register reads 0), the stopped status reads 1 and the interrupt is low.
- R2: The register is selected by address bits 4:2 and higher address bits are ignored. Index 0 is the limit with count restart, 1 the count, 2 the limit that keeps the count, 3 start/stop, 4 mode. Indices 5 to 7 read as zero and writes to them change nothing. Read data appears one cycle after the read strobe.
- R3: Each cycle with tick-enable high (and, in user mode, not stopped) adds 0x200 to the visible count. With tick-enable low the count holds.
- R4: A written limit is ANDed with 0x7FFFFE00. If the result is zero, 0x7FFFFE00 is stored instead.
- R5: A write to index 0 stores the limit, restarts the count at zero and drives the interrupt low.
- R6: A write to index 2 stores the limit, keeps the current count and leaves the interrupt unchanged.
- R7: In system mode, a tick that would bring the count to the limit or beyond sets the count to zero, sets the reached flag and raises the interrupt.
- R8: In system mode, a read of index 0 returns the limit with bit 31 zero, then clears the reached flag and drives the interrupt low. A read of index 1 returns the count in bits 30:0 with the reached flag in bit 31.
- R9: In user mode, a read of index 0 returns count bits 62:32 (bit 31 zero), a read of index 1 returns count bits 31:0, and the interrupt never rises.
- R10: In user mode only, a write to index 3 stops the counter when bit 0 is 1 and runs it when bit 0 is 0. In system mode such a write is ignored. Index 3 reads the stopped status in bit 0.
- R11: A write to index 4 sets the mode from bit 0 (1 user, 0 system) and restarts the count at zero. Entering user mode drives the interrupt low and sets the limit to 0x7FFFFFFF. Index 4 reads the mode in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| tick_en | input | 1 | Count-enable pulse, one tick per high cycle |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, high while a limit event is pending |

## Verification
The counter is driven in three ways:

- **Bursts of ticks separated by idle cycles.** These show whether the count moves only on enabled cycles.
- **Runs that cross the limit.** These show whether the wrap, the reached flag and the interrupt arrive together on the exact tick that meets the limit.
- **A limit raised with a count-preserving write in mid-run.** This tells the keep-count write apart from the restart write.

User mode is tried with the counter stopped, then running, then stopped again. This separates the stop control from tick gating and confirms that the same stop write is ignored after returning to system mode. Aliased and undefined addresses are mixed in, to show that only bits 4:2 decode.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CNT_SHIFT = 9;
  localparam int unsigned LIM_W     = DATA_W - 1;
  localparam int unsigned LTICK_W   = LIM_W - CNT_SHIFT;
  localparam int unsigned NREG      = 8;
  localparam logic [LIM_W-1:0] LIMIT_MASK = 31'h7FFF_FE00;
  localparam logic [LIM_W-1:0] LIMIT_USER = 31'h7FFF_FFFF;

  typedef enum logic [2:0] {
    IDX_LIM_RST  = 3'd0,
    IDX_COUNT    = 3'd1,
    IDX_LIM_KEEP = 3'd2,
    IDX_RUN      = 3'd3,
    IDX_MODE     = 3'd4
  } reg_idx_e;

  // Mask a written limit; a zero result becomes the largest legal limit
  function automatic logic [LIM_W-1:0] mask_limit(input logic [DATA_W-1:0] w);
    logic [LIM_W-1:0] m;
    m = w[LIM_W-1:0] & LIMIT_MASK;
    if (m == '0) m = LIMIT_MASK;
    return m;
  endfunction
endpackage

// File: rtl/dmt_regdec.sv
module dmt_regdec
  import dmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [2:0]        idx,
  output logic              w_lim_rst,
  output logic              w_lim_keep,
  output logic              w_run,
  output logic              w_mode,
  output logic              r_lim,
  output logic              cnt_clear
);
  logic [NREG-1:0] sel;

  assign idx = bus_addr[4:2];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (idx == 3'(i));
  end

  assign w_lim_rst  = bus_wr & sel[IDX_LIM_RST];
  assign w_lim_keep = bus_wr & sel[IDX_LIM_KEEP];
  assign w_run      = bus_wr & sel[IDX_RUN];
  assign w_mode     = bus_wr & sel[IDX_MODE];
  assign r_lim      = bus_rd & sel[IDX_LIM_RST];
  assign cnt_clear  = w_lim_rst | w_mode;
endmodule

// File: rtl/dmt_count.sv
module dmt_count
  import dmt_pkg::*;
#(
  parameter int unsigned TICK_W = 55
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               tick_en,
  input  logic               run,
  input  logic               clear,
  input  logic               wrap_en,
  input  logic [LTICK_W-1:0] limit_ticks,
  output logic [TICK_W-1:0]  ticks,
  output logic               hit
);
  logic [TICK_W-1:0] ticks_q, ticks_d, inc;
  logic              step, en;

  assign step = tick_en & run;
  assign en   = clear | step;
  assign inc  = ticks_q + TICK_W'(1);

  always_comb begin
    ticks_d = ticks_q;
    hit     = 1'b0;
    if (clear) begin
      ticks_d = '0;
    end else if (step) begin
      if (wrap_en && (inc >= TICK_W'(limit_ticks))) begin
        ticks_d = '0;
        hit     = 1'b1;
      end else begin
        ticks_d = inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  ticks_q <= '0;
    else if (en)  ticks_q <= ticks_d;
  end

  assign ticks = ticks_q;
endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              w_lim_rst,
  input  logic              w_lim_keep,
  input  logic              w_run,
  input  logic              w_mode,
  input  logic              r_lim,
  input  logic              hit,
  output logic [LIM_W-1:0]  limit,
  output logic              mode_user,
  output logic              stopped,
  output logic              reached,
  output logic              irq
);
  logic [LIM_W-1:0] limit_q, limit_d;
  logic mode_q, mode_d, stop_q, stop_d, reach_q, reach_d, irq_q, irq_d;
  logic upd;

  assign upd = w_lim_rst | w_lim_keep | w_run | w_mode | r_lim | hit;

  always_comb begin
    limit_d = limit_q;
    mode_d  = mode_q;
    stop_d  = stop_q;
    reach_d = reach_q;
    irq_d   = irq_q;
    if (w_lim_rst) begin
      limit_d = mask_limit(wdata);
      irq_d   = 1'b0;
    end
    if (w_lim_keep) limit_d = mask_limit(wdata);
    if (w_run && mode_q) stop_d = wdata[0];
    if (w_mode) begin
      mode_d = wdata[0];
      if (wdata[0]) begin
        limit_d = LIMIT_USER;
        irq_d   = 1'b0;
      end
    end
    if (r_lim && !mode_q) begin
      irq_d   = 1'b0;
      reach_d = 1'b0;
    end
    if (hit) begin
      irq_d   = 1'b1;
      reach_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      limit_q <= LIMIT_MASK;
      mode_q  <= 1'b0;
      stop_q  <= 1'b1;
      reach_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (upd) begin
      limit_q <= limit_d;
      mode_q  <= mode_d;
      stop_q  <= stop_d;
      reach_q <= reach_d;
      irq_q   <= irq_d;
    end
  end

  assign limit     = limit_q;
  assign mode_user = mode_q;
  assign stopped   = stop_q;
  assign reached   = reach_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dmt_rdmux.sv
module dmt_rdmux
  import dmt_pkg::*;
#(
  parameter int unsigned TICK_W = 55
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bus_rd,
  input  logic [2:0]        idx,
  input  logic              mode_user,
  input  logic [LIM_W-1:0]  limit,
  input  logic              reached,
  input  logic              stopped,
  input  logic [TICK_W-1:0] ticks,
  output logic [DATA_W-1:0] rdata
);
  logic [2*DATA_W-1:0] full;
  logic [DATA_W-1:0]   lo, hi, rd_d, rd_q;

  always_comb begin
    full = (2*DATA_W)'(ticks);
    full = full << CNT_SHIFT;
  end
  assign lo = full[DATA_W-1:0];
  assign hi = full[2*DATA_W-1:DATA_W];

  always_comb begin
    rd_d = '0;
    unique case (idx)
      IDX_LIM_RST:  rd_d = mode_user ? {1'b0, hi[DATA_W-2:0]} : {1'b0, limit};
      IDX_COUNT:    rd_d = mode_user ? lo : {reached, lo[DATA_W-2:0]};
      IDX_RUN:      rd_d = {{(DATA_W-1){1'b0}}, stopped};
      IDX_MODE:     rd_d = {{(DATA_W-1){1'b0}}, mode_user};
      default:      rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
  import dmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TICK_W = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              tick_en,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [1:0]         rst_sync;
  logic               rst_sn;
  logic [2:0]         idx;
  logic               w_lim_rst, w_lim_keep, w_run, w_mode, r_lim, cnt_clear;
  logic [LIM_W-1:0]   limit_w;
  logic               mode_w, stopped_w, reached_w, hit_w;
  logic [TICK_W-1:0]  ticks_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  dmt_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .idx(idx),
    .w_lim_rst(w_lim_rst), .w_lim_keep(w_lim_keep), .w_run(w_run),
    .w_mode(w_mode), .r_lim(r_lim), .cnt_clear(cnt_clear)
  );

  dmt_count #(.TICK_W(TICK_W)) u_cnt (
    .clk(clk), .rst_sn(rst_sn), .tick_en(tick_en),
    .run(!mode_w || !stopped_w), .clear(cnt_clear), .wrap_en(!mode_w),
    .limit_ticks(limit_w[LIM_W-1:CNT_SHIFT]), .ticks(ticks_w), .hit(hit_w)
  );

  dmt_ctrl u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .wdata(bus_wdata), .w_lim_rst(w_lim_rst),
    .w_lim_keep(w_lim_keep), .w_run(w_run), .w_mode(w_mode), .r_lim(r_lim),
    .hit(hit_w), .limit(limit_w), .mode_user(mode_w), .stopped(stopped_w),
    .reached(reached_w), .irq(irq)
  );

  dmt_rdmux #(.TICK_W(TICK_W)) u_rd (
    .clk(clk), .rst_sn(rst_sn), .bus_rd(bus_rd), .idx(idx),
    .mode_user(mode_w), .limit(limit_w), .reached(reached_w),
    .stopped(stopped_w), .ticks(ticks_w), .rdata(bus_rdata)
  );
endmodule

// File: rtl/dmt_timer_chk.sv
module dmt_timer_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TICK_W = 55
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              tick_en,
  input logic              irq,
  input logic              mode_user,
  input logic [30:0]       limit,
  input logic [TICK_W-1:0] ticks
);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!tick_en && !bus_wr) |=> $stable(ticks));

  // R4
  limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (limit[30:9] != '0));

  // R5
  restart_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && bus_addr[4:2] == 3'd0) |=> (ticks == '0 && !irq));

  // R7
  irq_with_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> (ticks == '0));

  // R8
  ack_read_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && !bus_wr && bus_addr[4:2] == 3'd0 && !mode_user && !tick_en) |=> !irq);

  // R9
  user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> !mode_user);
endmodule

bind dmt_timer dmt_timer_chk #(.ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .tick_en(tick_en), .irq(irq), .mode_user(mode_w),
  .limit(limit_w), .ticks(ticks_w)
);

// File: tb/test_dmt_timer.sv
`timescale 1ns/1ps
module test_dmt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr, bus_rd, tick_en;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dmt_timer i_dmt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .tick_en(tick_en),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: a read strobed at one edge has its data at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(8'h00, 32'h7FFF_FE00, "R1 limit");
    rd(8'h04, 32'h0, "R1 count");
    rd(8'h0C, 32'h1, "R1 stopped");
    rd(8'h10, 32'h0, "R1 mode");

    // R4 masking, R3 counting
    wr(8'h00, 32'h0000_0A55);
    rd(8'h00, 32'h0000_0A00, "R4 mask");
    ticks(3);
    rd(8'h04, 32'h0000_0600, "R3 three ticks");
    chk_irq(1'b0, "R7 before limit");
    // R7 wrap on the fifth tick
    ticks(2);
    chk_irq(1'b1, "R7 irq at limit");
    rd(8'h04, 32'h8000_0000, "R7 reached and wrap");
    // R8 acknowledge
    rd(8'h00, 32'h0000_0A00, "R8 limit read");
    chk_irq(1'b0, "R8 irq cleared");
    rd(8'h04, 32'h0, "R8 reached cleared");

    // R4 zero substitution
    wr(8'h00, 32'h0000_01FF);
    rd(8'h00, 32'h7FFF_FE00, "R4 zero limit");

    // R6 keep-count limit write
    wr(8'h00, 32'h0000_0A00);
    ticks(2);
    wr(8'h08, 32'h0000_1000);
    rd(8'h04, 32'h0000_0400, "R6 count kept");
    ticks(6);
    chk_irq(1'b1, "R7 irq at new limit");
    rd(8'h04, 32'h8000_0000, "R7 wrap at raised limit");
    wr(8'h08, 32'h0000_1000);
    chk_irq(1'b1, "R6 irq unchanged");
    // R5 restart write drops irq
    wr(8'h00, 32'h0000_1000);
    chk_irq(1'b0, "R5 irq low");
    rd(8'h00, 32'h0000_1000, "R5 limit stored");
    rd(8'h04, 32'h0, "R5 count zero");

    // R3 hold without tick-enable
    ticks(3);
    repeat (5) @(negedge clk);
    rd(8'h04, 32'h0000_0600, "R3 hold while idle");

    // R2 decode
    rd(8'h24, 32'h0000_0600, "R2 alias bit5");
    rd(8'h84, 32'h0000_0600, "R2 alias bit7");
    rd(8'h14, 32'h0, "R2 index5 zero");
    rd(8'h1C, 32'h0, "R2 index7 zero");
    wr(8'h18, 32'h1234_5678);
    rd(8'h04, 32'h0000_0600, "R2 index6 write no count effect");
    rd(8'h00, 32'h0000_1000, "R2 index6 write no limit effect");

    // R11 entering user mode
    ticks(5);
    chk_irq(1'b1, "R7 irq before user");
    wr(8'h10, 32'h1);
    chk_irq(1'b0, "R11 irq low in user");
    rd(8'h10, 32'h1, "R11 mode user");
    rd(8'h04, 32'h0, "R11 count reload");
    // R10 still stopped from reset
    rd(8'h0C, 32'h1, "R10 stopped");
    ticks(3);
    rd(8'h04, 32'h0, "R10 stopped no count");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0, "R10 running");
    ticks(4);
    rd(8'h04, 32'h0000_0800, "R9 low word");
    rd(8'h00, 32'h0, "R9 high word");
    wr(8'h0C, 32'h1);
    ticks(3);
    rd(8'h04, 32'h0000_0800, "R10 stop freezes");
    chk_irq(1'b0, "R9 no irq in user");

    // back to system mode
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h0, "R11 mode system");
    rd(8'h00, 32'h7FFF_FFFF, "R11 limit all ones");
    rd(8'h04, 32'h0, "R11 reload on mode write");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h1, "R10 ignored in system");
    ticks(2);
    rd(8'h04, 32'h0000_0400, "R10 system runs while stopped");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: pending reads actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule